// File: doc/BRIEF.md
# Leveled Bus Interrupt Controller

This block collects interrupt requests from a backplane bus that carries seven prioritized request levels. It also collects a set of single-cycle event sources: a bus-ownership event, power-fail, system-fail, a software interrupt, a software acknowledge, a bus error, a local error and DMA completion. Every source has one status bit and one enable bit. A 3-bit mapping field per source steers it onto one of eight local interrupt lines. A line is asserted while any enabled source that is routed to it has its status bit set.

A bus level is not latched directly from the request pin. While a level is requested and enabled, and its status bit is clear, the block runs a simplified acknowledge handshake for that level. The block serves one level at a time, always the highest eligible level. The responder returns an 8-bit vector and an error flag. In the cycle the handshake completes, the block sets the level's status bit and stores the vector and error flag in that level's status/ID register. Software reads the priority register to find the highest pending level, reads that level's status/ID, and clears the status bit by writing 1 to it.

Top module: `irq_lvl_ctrl`

## Requirements
- R1: A request on a bus level whose enable bit is clear starts no acknowledge and sets no status bit.
- R2: Acknowledges run one at a time. `ack_req_o` and `ack_lvl_o` (value 1..7) hold steady until `ack_done_i`. When several eligible levels wait, the highest level is served first.
- R3: No acknowledge starts for a level whose status bit is already set, even while its request stays asserted.
- R4: When `ack_done_i` is seen with `ack_req_o` high and the level still enabled, the status bit of that level is set. Status bit n holds level n. In the same cycle, the status/ID register of level n (address 8+n) captures the vector in bits 7:0 and the error flag in bit 8.
- R5: The bus-ownership event (status/enable bit 0) and the special events (bits 14:8, in the order power-fail, system-fail, software interrupt, software acknowledge, bus error, local error, DMA) set their status bit only while their enable bit is set.
- R6: Line k of `irq_o` is high while at least one source has status and enable both set and a mapping field equal to k. The level map (address 2) holds source i (0 = ownership, 1..7 = levels) in bits 3i+2:3i. The special map (address 3) holds special j in bits 3j+2:3j.
- R7: Clearing an enable bit removes that source from the output lines but leaves its status bit set.
- R8: Writing the status register (address 1) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R9: If a source sets its status bit in the same cycle as a write of 1 to that bit, the bit ends up set.
- R10: `prio_o` and the read-only register at address 4 give the highest level whose status bit is set, or 0 when no level status is set. Writes to address 4 have no effect.
- R11: Reset clears all enable bits, both mapping registers, all status bits and all status/ID registers, and leaves no acknowledge pending.
- R12: The enable register is at address 0 with the same bit layout as status. Unused read bits return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| lvl_req_i | input | 7 | Bus request levels, bit i = level i+1 |
| own_evt_i | input | 1 | Bus-ownership event |
| spec_evt_i | input | 7 | Special events, same order as status bits 14:8 |
| ack_req_o | output | 1 | Acknowledge cycle in progress |
| ack_lvl_o | output | 3 | Level being acknowledged |
| ack_done_i | input | 1 | Responder completes the acknowledge |
| ack_vec_i | input | 8 | Vector returned by the responder |
| ack_err_i | input | 1 | Acknowledge failed |
| irq_o | output | 8 | Local interrupt lines |
| prio_o | output | 3 | Highest level with status set |

## Verification
The bench asserts two levels at once and expects the higher one to be acknowledged first. A design that picks the lowest level or scans by index would swap the acknowledge order. It holds a request high after its status is latched. A design that does not gate on status would start repeated acknowledges, and the scoreboard reports each one as unexpected. It clears an enable while status is set, then clears status while the request is still held and the level is disabled. This catches a design that clears status along with the enable, or that acknowledges disabled levels. It also fires an event in the same cycle as the write-one-to-clear of that event's bit. A design where the clear wins would lose the event.

// File: rtl/irq_lvl_pkg.sv
`timescale 1ns/1ps
package irq_lvl_pkg;
    localparam int NUM_LVL  = 7;
    localparam int NUM_SPEC = 7;
    localparam int NUM_LINE = 8;
    localparam int VEC_W    = 8;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 4;

    localparam int LVL_W    = $clog2(NUM_LVL + 1);
    localparam int LINE_W   = $clog2(NUM_LINE);
    localparam int NUM_SRC  = 1 + NUM_LVL + NUM_SPEC;
    localparam int SPEC_LO  = 1 + NUM_LVL;
    localparam int MAPL_W   = (1 + NUM_LVL) * LINE_W;
    localparam int MAPS_W   = NUM_SPEC * LINE_W;
    localparam int SID_BASE = 8;

    localparam logic [ADDR_W-1:0] ADR_EN   = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADR_STAT = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ADR_MAPL = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] ADR_MAPS = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] ADR_PRIO = ADDR_W'(4);

    typedef struct packed {
        logic              err;
        logic [VEC_W-1:0]  vec;
    } statid_t;

    typedef enum logic {SEQ_IDLE, SEQ_WAIT} seq_e;

    // Highest set position, reported as level number (index + 1); 0 if none.
    function automatic logic [LVL_W-1:0] top_level(input logic [NUM_LVL-1:0] v);
        logic [LVL_W-1:0] r;
        r = '0;
        for (int i = 0; i < NUM_LVL; i++)
            if (v[i]) r = LVL_W'(i + 1);
        return r;
    endfunction
endpackage

// File: rtl/irq_ack_seq.sv
`timescale 1ns/1ps
module irq_ack_seq
    import irq_lvl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_LVL-1:0] req,
    input  logic [NUM_LVL-1:0] en_lvl,
    input  logic [NUM_LVL-1:0] stat_lvl,
    input  logic               done,
    output logic               ack_req,
    output logic [LVL_W-1:0]   ack_lvl
);
    seq_e             state_q;
    logic [LVL_W-1:0] lvl_q;
    logic [LVL_W-1:0] pick;

    // eligible: requested, enabled, and not already holding status
    assign pick = top_level(req & en_lvl & ~stat_lvl);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            lvl_q   <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: if (pick != '0) begin
                    state_q <= SEQ_WAIT;
                    lvl_q   <= pick;
                end
                SEQ_WAIT: if (done) begin
                    state_q <= SEQ_IDLE;
                    lvl_q   <= '0;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign ack_req = (state_q == SEQ_WAIT);
    assign ack_lvl = lvl_q;
endmodule

// File: rtl/irq_route.sv
`timescale 1ns/1ps
module irq_route #(
    parameter int NS = 15,
    parameter int NL = 8,
    parameter int LW = 3
) (
    input  logic [NS-1:0]    active,
    input  logic [NS*LW-1:0] map,
    output logic [NL-1:0]    lines
);
    for (genvar k = 0; k < NL; k++) begin : g_line
        logic [NS-1:0] hit;
        for (genvar s = 0; s < NS; s++) begin : g_src
            assign hit[s] = active[s] && (map[s*LW +: LW] == LW'(k));
        end
        assign lines[k] = |hit;
    end
endmodule

// File: rtl/irq_lvl_ctrl.sv
`timescale 1ns/1ps
module irq_lvl_ctrl
    import irq_lvl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [NUM_LVL-1:0]  lvl_req_i,
    input  logic                own_evt_i,
    input  logic [NUM_SPEC-1:0] spec_evt_i,
    output logic                ack_req_o,
    output logic [LVL_W-1:0]    ack_lvl_o,
    input  logic                ack_done_i,
    input  logic [VEC_W-1:0]    ack_vec_i,
    input  logic                ack_err_i,
    output logic [NUM_LINE-1:0] irq_o,
    output logic [LVL_W-1:0]    prio_o
);
    logic [NUM_SRC-1:0] en_q, stat_q, set_vec, clr_vec;
    logic [MAPL_W-1:0]  mapl_q;
    logic [MAPS_W-1:0]  maps_q;
    statid_t            sid_q [NUM_LVL];
    logic               cap;
    logic               unused_wbits;

    assign unused_wbits = ^reg_wdata[DATA_W-1:MAPL_W];

    irq_ack_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .req      (lvl_req_i),
        .en_lvl   (en_q[1 +: NUM_LVL]),
        .stat_lvl (stat_q[1 +: NUM_LVL]),
        .done     (ack_done_i),
        .ack_req  (ack_req_o),
        .ack_lvl  (ack_lvl_o)
    );

    assign cap = ack_req_o & ack_done_i;

    always_comb begin
        set_vec    = '0;
        set_vec[0] = own_evt_i & en_q[0];
        for (int l = 1; l <= NUM_LVL; l++)
            set_vec[l] = cap && (ack_lvl_o == LVL_W'(l)) && en_q[l];
        set_vec[SPEC_LO +: NUM_SPEC] = spec_evt_i & en_q[SPEC_LO +: NUM_SPEC];
    end

    assign clr_vec = (reg_we && reg_addr == ADR_STAT) ? reg_wdata[NUM_SRC-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            mapl_q <= '0;
            maps_q <= '0;
            stat_q <= '0;
        end else begin
            if (reg_we) begin
                case (reg_addr)
                    ADR_EN:   en_q   <= reg_wdata[NUM_SRC-1:0];
                    ADR_MAPL: mapl_q <= reg_wdata[MAPL_W-1:0];
                    ADR_MAPS: maps_q <= reg_wdata[MAPS_W-1:0];
                    default: ;
                endcase
            end
            // a new set beats a simultaneous clear
            stat_q <= (stat_q & ~clr_vec) | set_vec;
        end
    end

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_sid
        always_ff @(posedge clk) begin
            if (rst)
                sid_q[g] <= '0;
            else if (set_vec[g + 1])
                sid_q[g] <= '{err: ack_err_i, vec: ack_vec_i};
        end
    end

    irq_route #(
        .NS (NUM_SRC),
        .NL (NUM_LINE),
        .LW (LINE_W)
    ) u_route (
        .active (stat_q & en_q),
        .map    ({maps_q, mapl_q}),
        .lines  (irq_o)
    );

    assign prio_o = top_level(stat_q[1 +: NUM_LVL]);

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADR_EN:   reg_rdata[NUM_SRC-1:0] = en_q;
            ADR_STAT: reg_rdata[NUM_SRC-1:0] = stat_q;
            ADR_MAPL: reg_rdata[MAPL_W-1:0]  = mapl_q;
            ADR_MAPS: reg_rdata[MAPS_W-1:0]  = maps_q;
            ADR_PRIO: reg_rdata[LVL_W-1:0]   = prio_o;
            default: begin
                for (int l = 1; l <= NUM_LVL; l++)
                    if (reg_addr == ADDR_W'(SID_BASE + l))
                        reg_rdata[$bits(statid_t)-1:0] = sid_q[l-1];
            end
        endcase
    end
endmodule

// File: rtl/irq_lvl_ctrl_chk.sv
`timescale 1ns/1ps
module irq_lvl_ctrl_chk
    import irq_lvl_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                ack_req,
    input logic [LVL_W-1:0]    ack_lvl,
    input logic                ack_done,
    input logic [NUM_LINE-1:0] irq,
    input logic [LVL_W-1:0]    prio,
    input logic [NUM_SRC-1:0]  stat,
    input logic [NUM_SRC-1:0]  en
);
    // R2
    ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ack_req && !ack_done |=> ack_req && $stable(ack_lvl));

    // R2
    ack_lvl_valid_chk: assert property (@(posedge clk) disable iff (rst)
        ack_req |-> ack_lvl != '0);

    // R3
    ack_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        ack_req |-> !stat[ack_lvl]);

    // R4
    cap_sets_stat_chk: assert property (@(posedge clk) disable iff (rst)
        ack_req && ack_done && en[ack_lvl] |=> stat[$past(ack_lvl)]);

    // R6
    line_has_src_chk: assert property (@(posedge clk) disable iff (rst)
        (|irq) |-> (|(stat & en)));

    // R10
    prio_set_chk: assert property (@(posedge clk) disable iff (rst)
        prio != '0 |-> stat[prio]);

    // R10
    prio_none_chk: assert property (@(posedge clk) disable iff (rst)
        prio == '0 |-> stat[NUM_LVL:1] == '0);
endmodule

bind irq_lvl_ctrl irq_lvl_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ack_req  (ack_req_o),
    .ack_lvl  (ack_lvl_o),
    .ack_done (ack_done_i),
    .irq      (irq_o),
    .prio     (prio_o),
    .stat     (stat_q),
    .en       (en_q)
);

// File: tb/irq_lvl_ctrl_tb.sv
`timescale 1ns/1ps
module irq_lvl_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [6:0]  lvl_req = '0;
    logic        own_evt = 1'b0;
    logic [6:0]  spec_evt = '0;
    logic        ack_req;
    logic [2:0]  ack_lvl;
    logic        ack_done = 1'b0;
    logic [7:0]  ack_vec = '0;
    logic        ack_err = 1'b0;
    logic [7:0]  irq;
    logic [2:0]  prio;

    int n_chk = 0;
    int n_fail = 0;
    int exp_q[$];
    int err_lvl = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    irq_lvl_ctrl u_dut (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .lvl_req_i(lvl_req), .own_evt_i(own_evt), .spec_evt_i(spec_evt),
        .ack_req_o(ack_req), .ack_lvl_o(ack_lvl), .ack_done_i(ack_done),
        .ack_vec_i(ack_vec), .ack_err_i(ack_err),
        .irq_o(irq), .prio_o(prio)
    );

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string rq, input logic [3:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(rq, reg_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Scoreboard monitor + responder: each new acknowledge is compared
    // against the next expected level, then answered with a vector.
    always @(negedge clk) begin
        if (rst) begin
            ack_done = 1'b0;
        end else if (ack_req && !ack_done) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R1/R2/R3 unexpected acknowledge actual=%0d expected=none", ack_lvl);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (int'(ack_lvl) != e) begin
                    n_fail++;
                    $display("FAIL R2 acknowledge order actual=%0d expected=%0d", ack_lvl, e);
                end
            end
            ack_vec  = 8'hA0 | 8'(ack_lvl);
            ack_err  = (int'(ack_lvl) == err_lvl);
            ack_done = 1'b1;
        end else begin
            ack_done = 1'b0;
        end
    end

    initial begin
        idle(4);
        @(negedge clk); rst = 1'b0;

        // R11 reset state
        rd_chk("R11 enable", 4'd0, 32'h0);
        rd_chk("R11 status", 4'd1, 32'h0);
        rd_chk("R11 level map", 4'd2, 32'h0);
        rd_chk("R11 special map", 4'd3, 32'h0);
        rd_chk("R11 status/ID", 4'd13, 32'h0);
        check("R11 irq lines", 32'(irq), 32'h0);
        check("R11 ack idle", 32'(ack_req), 32'h0);

        // R1 disabled level ignored
        @(negedge clk); lvl_req = 7'b0000100;
        idle(6);
        rd_chk("R1 no status when disabled", 4'd1, 32'h0);
        @(negedge clk); lvl_req = '0;

        // R2/R4/R6/R10: levels 3 and 5, higher served first
        wr(4'd2, (32'd2 << 9) | (32'd6 << 15));
        wr(4'd0, 32'h28);
        exp_q.push_back(5);
        exp_q.push_back(3);
        @(negedge clk); lvl_req = 7'b0010100;
        idle(10);
        check("R2 all acks served", 32'(exp_q.size()), 32'h0);
        rd_chk("R4 status levels 3,5", 4'd1, 32'h28);
        rd_chk("R4 status/ID level 5", 4'd13, 32'h0A5);
        rd_chk("R4 status/ID level 3", 4'd11, 32'h0A3);
        check("R6 lines 2 and 6", 32'(irq), 32'h44);
        check("R10 prio output", 32'(prio), 32'd5);
        rd_chk("R10 prio register", 4'd4, 32'd5);
        wr(4'd4, 32'h7);
        rd_chk("R10 prio write ignored", 4'd4, 32'd5);
        rd_chk("R12 enable readback", 4'd0, 32'h28);

        // R3 requests held with status set: no further acknowledge
        idle(8);
        rd_chk("R3 status unchanged", 4'd1, 32'h28);

        // R7 disable level 5 masks line 6, status kept
        wr(4'd0, 32'h08);
        check("R7 line 6 masked", 32'(irq), 32'h04);
        rd_chk("R7 status kept", 4'd1, 32'h28);

        // R8 write-one-to-clear bit 5 only
        wr(4'd1, 32'h20);
        rd_chk("R8 clear one bit", 4'd1, 32'h08);
        check("R10 prio drops to 3", 32'(prio), 32'd3);
        idle(4);
        rd_chk("R1 disabled held request ignored", 4'd1, 32'h08);

        // re-enable 5: a fresh acknowledge follows
        exp_q.push_back(5);
        wr(4'd0, 32'h28);
        idle(6);
        rd_chk("R4 level 5 relatched", 4'd1, 32'h28);
        @(negedge clk); lvl_req = '0;
        wr(4'd1, 32'h28);
        rd_chk("R8 clear both", 4'd1, 32'h0);
        check("R6 lines idle", 32'(irq), 32'h0);
        check("R10 prio none", 32'(prio), 32'd0);

        // R4 error flag on level 7
        err_lvl = 7;
        wr(4'd0, 32'hA8);
        exp_q.push_back(7);
        @(negedge clk); lvl_req = 7'b1000000;
        idle(6);
        @(negedge clk); lvl_req = '0;
        rd_chk("R4 status/ID level 7 with error", 4'd15, 32'h1A7);
        rd_chk("R4 status level 7", 4'd1, 32'h80);
        check("R6 level 7 on line 0", 32'(irq), 32'h01);
        check("R10 prio 7", 32'(prio), 32'd7);
        wr(4'd1, 32'h80);

        // R5/R6 special and ownership events
        wr(4'd3, (32'd7 << 18) | (32'd3 << 3));
        wr(4'd2, (32'd2 << 9) | (32'd6 << 15) | 32'd4);
        wr(4'd0, 32'h40A9);
        @(negedge clk); spec_evt = 7'b1000010; own_evt = 1'b1;
        @(negedge clk); spec_evt = '0; own_evt = 1'b0;
        rd_chk("R5 enabled events latched, system-fail ignored", 4'd1, 32'h4001);
        check("R6 lines 4 and 7", 32'(irq), 32'h90);
        check("R10 no level pending", 32'(prio), 32'd0);

        // R9 set beats simultaneous clear
        @(negedge clk);
        spec_evt = 7'b1000000;
        reg_we = 1'b1; reg_addr = 4'd1; reg_wdata = 32'h4000;
        @(negedge clk);
        spec_evt = '0; reg_we = 1'b0;
        rd_chk("R9 set wins", 4'd1, 32'h4001);
        wr(4'd1, 32'h4001);
        rd_chk("R8 all cleared", 4'd1, 32'h0);
        check("R6 lines idle at end", 32'(irq), 32'h0);
        check("R2 no stray acks", 32'(exp_q.size()), 32'h0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule